// File: doc/BRIEF.md
# SPI Data FIFO and Interrupt Unit

This block holds the transmit and receive data queues of an SPI controller, together with their status flags and interrupt logic. Software reaches it through a small register port: it writes transmit words into one address and reads received words from another. The serial engine is not part of the block. It is represented by strobes: the engine takes one word from the transmit queue, or puts one word into the receive queue, on each strobe.

The unit raises four interrupt sources. Two follow the fill levels of the queues against thresholds chosen from a 3-bit code. The other two are sticky error events: a receive overflow, and a receive timeout that fires when received data sits unread. Each source has a raw bit and a mask bit, and the masked bits are combined into a single interrupt line. Only the two error sources can be cleared by software. The level sources drop by themselves once the fill level leaves the active range.

Top module: `spi_fifo_irq`

## Requirements
- R1: Each queue holds up to DEPTH (default 256) words and returns them in first-in first-out order. A write to address 2 pushes a transmit word. While the queue is not empty, `eng_tx_valid_o` is high and `eng_tx_data_o` shows the oldest word, which is popped on `eng_tx_take_i`. A high `eng_rx_put_i` pushes `eng_rx_data_i`. A read of address 3 returns the oldest receive word and pops it. A read of address 3 while the receive queue is empty returns 0.
- R2: A read of address 4 returns the status word. Bit 0 is transmit queue empty, bit 1 is transmit queue not full, bit 2 is receive queue not empty, bit 3 is receive queue full, and bit 4 is busy. Busy is `eng_busy_i` OR the transmit queue not empty.
- R3: A receive strobe while the receive queue is full drops the word and sets raw bit 0 (overflow). The receive queue contents stay unchanged.
- R4: Raw bit 1 (timeout) is set when the receive queue is non-empty and neither a receive strobe nor a read of address 3 has occurred for T consecutive cycles. T is held in bits 31:16 of the level word. If the last activity happens at clock edge E0, the bit is set at edge E(T). T = 0 disables the timeout.
- R5: Raw bit 2 is 1 while the receive fill count is at or above L(rx code). The rx code sits in bits 11:9 of the level word. L(0)=1, and L(c)=2^(c+1) for c = 1..6, which gives 4, 8, 16, 32, 64 and 128. Code 7 is treated as 128.
- R6: Raw bit 3 is 1 while the transmit fill count is at or below L(tx code). The tx code sits in bits 5:3 of the level word, and L is the same mapping as in R5.
- R7: The mask register is at address 1 (bits 3:0) and resets to 4'hF. A mask bit of 1 blocks its source. Address 6 reads raw AND NOT mask. `irq_o` is the OR of those masked bits.
- R8: Writing address 7 clears raw bit 0 and/or raw bit 1 wherever the written data has a 1. If a set event occurs in the same cycle, the set wins. Written bits 3:2 have no effect.
- R9: The register map is: 0 level word, 1 mask, 2 transmit data (write only), 3 receive data, 4 status, 5 raw, 6 masked, 7 clear. Addresses 2 and 7 read as 0. At reset the level word is 0.
- R10: A transmit write while the transmit queue is full is dropped. The transmit count stays at DEPTH and the queued words stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the access cycle |
| eng_tx_valid_o | output | 1 | Transmit queue has a word |
| eng_tx_data_o | output | DATA_W | Oldest transmit word |
| eng_tx_take_i | input | 1 | Engine takes the oldest transmit word |
| eng_rx_put_i | input | 1 | Engine delivers a received word |
| eng_rx_data_i | input | DATA_W | Received word |
| eng_busy_i | input | 1 | Engine is shifting |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that a register access lasts one cycle and carries a settled address, and that the engine strobes are single-cycle pulses. They also assume the engine never takes a word while `eng_tx_valid_o` is low. The bench drives every stimulus one cycle at a time from the falling edge. It pulses the take strobe only after it has seen the valid flag, and it keeps accesses and strobes in separate cycles. The threshold sweeps walk every code across every fill count from empty to full, so each level boundary is met from below.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned AW    = 3;

  localparam logic [AW-1:0] A_LVL  = 3'd0;
  localparam logic [AW-1:0] A_MASK = 3'd1;
  localparam logic [AW-1:0] A_TXD  = 3'd2;
  localparam logic [AW-1:0] A_RXD  = 3'd3;
  localparam logic [AW-1:0] A_STAT = 3'd4;
  localparam logic [AW-1:0] A_RAW  = 3'd5;
  localparam logic [AW-1:0] A_MSK  = 3'd6;
  localparam logic [AW-1:0] A_CLR  = 3'd7;

  // interrupt bit positions
  localparam int unsigned I_OVF = 0;
  localparam int unsigned I_TO  = 1;
  localparam int unsigned I_RXL = 2;
  localparam int unsigned I_TXL = 3;
  localparam int unsigned N_IRQ = 4;

  // level word fields
  localparam int unsigned TX_CODE_LSB = 3;
  localparam int unsigned RX_CODE_LSB = 9;
  localparam int unsigned TO_LSB      = 16;
endpackage

// File: rtl/sfi_fifo.sv
module sfi_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = PW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  a_r10_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i |=> full_o);
  a_r1_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i |=> empty_o);
  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/sfi_level_cmp.sv
module sfi_level_cmp #(
  parameter int unsigned CW       = 9,
  parameter bit          AT_ABOVE = 1'b1
) (
  input  logic [2:0]    code_i,
  input  logic [CW-1:0] count_i,
  output logic          hit_o
);
  logic [CW-1:0] lvl;

  // 0 -> 1, 1..6 -> 2^(c+1), 7 saturates at 128
  always_comb begin
    if (code_i == 3'd0)       lvl = CW'(1);
    else if (code_i >= 3'd6)  lvl = CW'(128);
    else                      lvl = CW'(1) << (code_i + 3'd1);
  end

  generate
    if (AT_ABOVE) begin : g_ge
      assign hit_o = (count_i >= lvl);
    end else begin : g_le
      assign hit_o = (count_i <= lvl);
    end
  endgenerate
endmodule

// File: rtl/sfi_rx_timeout.sv
module sfi_rx_timeout #(
  parameter int unsigned TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          nonempty_i,
  input  logic          activity_i,
  input  logic [TW-1:0] limit_i,
  output logic          fire_o
);
  logic [TW-1:0] cnt_q;
  logic          idle;

  assign idle   = nonempty_i && !activity_i;
  assign fire_o = idle && (limit_i != '0) && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!idle)         cnt_q <= '0;
    else if (cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
  end

  a_r4_fire_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned TO_W   = 16,
  localparam int unsigned CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_en_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              eng_tx_valid_o,
  output logic [DATA_W-1:0] eng_tx_data_o,
  input  logic              eng_tx_take_i,
  input  logic              eng_rx_put_i,
  input  logic [DATA_W-1:0] eng_rx_data_i,
  input  logic              eng_busy_i,
  output logic              irq_o
);
  logic [2:0]        tx_code_q, rx_code_q;
  logic [TO_W-1:0]   to_lim_q;
  logic [N_IRQ-1:0]  mask_q;
  logic [1:0]        err_q;

  logic              wr, rd;
  logic              tx_push, rx_pop;
  logic [DATA_W-1:0] rx_head;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              rx_hit, tx_hit, to_fire, ovf_evt;
  logic [N_IRQ-1:0]  raw, msk;
  logic [4:0]        stat;
  logic [31:0]       lvl_word;

  assign wr      = reg_en_i && reg_we_i;
  assign rd      = reg_en_i && !reg_we_i;
  assign tx_push = wr && (reg_addr_i == A_TXD);
  assign rx_pop  = rd && (reg_addr_i == A_RXD);

  sfi_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .wdata_i(reg_wdata_i[DATA_W-1:0]),
    .pop_i(eng_tx_take_i), .rdata_o(eng_tx_data_o),
    .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  sfi_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(eng_rx_put_i), .wdata_i(eng_rx_data_i),
    .pop_i(rx_pop), .rdata_o(rx_head),
    .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  sfi_level_cmp #(.CW(CW), .AT_ABOVE(1'b1)) u_rx_lvl (
    .code_i(rx_code_q), .count_i(rx_cnt), .hit_o(rx_hit)
  );
  sfi_level_cmp #(.CW(CW), .AT_ABOVE(1'b0)) u_tx_lvl (
    .code_i(tx_code_q), .count_i(tx_cnt), .hit_o(tx_hit)
  );

  sfi_rx_timeout #(.TW(TO_W)) u_to (
    .clk_i, .rst_ni,
    .nonempty_i(!rx_empty), .activity_i(eng_rx_put_i || rx_pop),
    .limit_i(to_lim_q), .fire_o(to_fire)
  );

  assign eng_tx_valid_o = !tx_empty;
  assign ovf_evt        = eng_rx_put_i && rx_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_code_q <= '0;
      rx_code_q <= '0;
      to_lim_q  <= '0;
      mask_q    <= '1;
      err_q     <= '0;
    end else begin
      if (wr && reg_addr_i == A_LVL) begin
        tx_code_q <= reg_wdata_i[TX_CODE_LSB +: 3];
        rx_code_q <= reg_wdata_i[RX_CODE_LSB +: 3];
        to_lim_q  <= reg_wdata_i[TO_LSB +: TO_W];
      end
      if (wr && reg_addr_i == A_MASK) mask_q <= reg_wdata_i[N_IRQ-1:0];
      // set wins over clear
      err_q[I_OVF] <= ovf_evt ||
        (err_q[I_OVF] && !(wr && reg_addr_i == A_CLR && reg_wdata_i[I_OVF]));
      err_q[I_TO]  <= to_fire ||
        (err_q[I_TO] && !(wr && reg_addr_i == A_CLR && reg_wdata_i[I_TO]));
    end
  end

  assign raw   = {tx_hit, rx_hit, err_q};
  assign msk   = raw & ~mask_q;
  assign irq_o = |msk;
  assign stat  = {eng_busy_i || !tx_empty, rx_full, !rx_empty, !tx_full, tx_empty};

  always_comb begin
    lvl_word = '0;
    lvl_word[TX_CODE_LSB +: 3] = tx_code_q;
    lvl_word[RX_CODE_LSB +: 3] = rx_code_q;
    lvl_word[TO_LSB +: TO_W]   = to_lim_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_LVL:  reg_rdata_o = lvl_word;
      A_MASK: reg_rdata_o = 32'(mask_q);
      A_RXD:  reg_rdata_o = rx_empty ? '0 : 32'(rx_head);
      A_STAT: reg_rdata_o = 32'(stat);
      A_RAW:  reg_rdata_o = 32'(raw);
      A_MSK:  reg_rdata_o = 32'(msk);
      default: reg_rdata_o = '0;
    endcase
  end

  a_r3_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full && eng_rx_put_i |=> err_q[I_OVF] && rx_full);
  a_r8_clear_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && reg_addr_i == A_CLR && reg_wdata_i[I_OVF] && !eng_rx_put_i |=> !err_q[I_OVF]);
  a_r7_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '1) |-> !irq_o);
  a_r4_to_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q[I_TO]) |-> $past(!rx_empty));
endmodule

// File: tb/spi_fifo_irq_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_irq_tb_top;
  localparam int DW = 32;
  localparam int DEPTH = 256;

  logic clk = 0, rst_n = 0;
  logic reg_en = 0, reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic tx_valid, tx_take = 0, rx_put = 0, busy = 0, irq;
  logic [DW-1:0] tx_data, rx_data = 0;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  spi_fifo_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_en_i(reg_en), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .eng_tx_valid_o(tx_valid), .eng_tx_data_o(tx_data), .eng_tx_take_i(tx_take),
    .eng_rx_put_i(rx_put), .eng_rx_data_i(rx_data), .eng_busy_i(busy),
    .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int lvl(int c);
    if (c == 0) return 1;
    if (c >= 6) return 128;
    return 2 << c;
  endfunction

  // all tasks start and end at a falling edge
  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_en = 1; reg_we = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_en = 0;
  endtask

  task automatic put(logic [31:0] d);
    rx_put = 1; rx_data = d;
    @(negedge clk);
    rx_put = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    rd(3'd4, v); check("R2 reset status", v, 32'h3);
    rd(3'd5, v); check("R6 reset raw", v, 32'h8);
    rd(3'd1, v); check("R7 reset mask", v, 32'hF);
    rd(3'd6, v); check("R7 reset masked", v, 32'h0);
    check("R7 reset irq", irq, 0);
    rd(3'd0, v); check("R9 reset level word", v, 32'h0);
    rd(3'd3, v); check("R1 empty read zero", v, 32'h0);
    rd(3'd2, v); check("R9 txd reads zero", v, 32'h0);

    // R5 sweep over every rx code and fill level
    for (int c = 0; c < 8; c++) begin
      wr(3'd0, 32'(c) << 9);
      rd(3'd0, v); check("R9 level readback", v, 32'(c) << 9);
      for (int n = 0; n <= DEPTH; n++) begin
        rd(3'd5, v);
        if (v[2] !== (n >= lvl(c))) check("R5 rx level", v[2], (n >= lvl(c)));
        else checks++;
        if (n < DEPTH) put((c << 16) | n);
      end
      rd(3'd4, v); check("R2 rx full status", v[3:2], 2'b11);
      if (c == 7) begin
        put(32'hDEAD);
        rd(3'd5, v); check("R3 overflow raw", v[0], 1);
        rd(3'd4, v); check("R3 still full", v[3], 1);
      end
      for (int n = 0; n < DEPTH; n++) begin
        rd(3'd3, v);
        if (v !== ((c << 16) | n)) check("R1 rx order", v, (c << 16) | n);
        else checks++;
      end
      rd(3'd4, v); check("R2 rx empty status", v[3:2], 2'b00);
      rd(3'd3, v); check("R3 dropped word absent", v, 0);
    end

    // clear behaviour
    wr(3'd7, 32'hC);
    rd(3'd5, v); check("R8 bits 3:2 unaffected", v, 32'h9);
    wr(3'd7, 32'h1);
    rd(3'd5, v); check("R8 overflow cleared", v, 32'h8);

    // mask
    wr(3'd1, 32'h7);
    rd(3'd6, v); check("R7 masked status", v, 32'h8);
    check("R7 irq unmasked", irq, 1);
    wr(3'd1, 32'hF);
    check("R7 irq masked", irq, 0);

    // R6 sweep over every tx code
    for (int c = 0; c < 8; c++) begin
      wr(3'd0, 32'(c) << 3);
      for (int n = 0; n <= DEPTH; n++) begin
        rd(3'd5, v);
        if (v[3] !== (n <= lvl(c))) check("R6 tx level", v[3], (n <= lvl(c)));
        else checks++;
        if (n < DEPTH) wr(3'd2, (c << 16) | n);
      end
      rd(3'd4, v); check("R2 tx full status", v[4:0], 5'b10000);
      wr(3'd2, 32'hBEEF);
      rd(3'd4, v); check("R10 full write dropped", v[1], 0);
      for (int n = 0; n < DEPTH; n++) begin
        #1;
        if (tx_valid !== 1 || tx_data !== ((c << 16) | n))
          check("R1 tx order", {tx_valid, tx_data[30:0]}, {1'b1, 31'((c << 16) | n)});
        else checks++;
        tx_take = 1;
        @(negedge clk);
        tx_take = 0;
      end
      #1 check("R10 no extra word", tx_valid, 0);
      rd(3'd4, v); check("R2 tx empty status", v[4:0], 5'b00011);
    end

    busy = 1;
    rd(3'd4, v); check("R2 engine busy", v[4], 1);
    busy = 0;

    // R4 timeout with T=5
    wr(3'd0, 32'd5 << 16);
    put(32'h55);
    idle(4);
    rd(3'd5, v); check("R4 no timeout before T", v[1], 0);
    rd(3'd5, v); check("R4 timeout at T", v[1], 1);
    wr(3'd1, 32'hD);
    check("R7 timeout drives irq", irq, 1);
    wr(3'd7, 32'h2);
    idle(10);
    rd(3'd5, v); check("R8 timeout cleared stays", v[1], 0);
    check("R8 irq after clear", irq, 0);
    rd(3'd3, v); check("R1 timeout word", v, 32'h55);
    idle(10);
    rd(3'd5, v); check("R4 empty no timeout", v[1], 0);

    // T=0 disables
    wr(3'd0, 32'h0);
    put(32'h66);
    idle(30);
    rd(3'd5, v); check("R4 disabled", v[1], 0);
    rd(3'd3, v); check("R1 read back", v, 32'h66);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule